// File: doc/BRIEF.md
# Clock Synthesizer Serial Configuration Register Bank

This block sits behind a two-wire serial slave that has already turned the bus into whole bytes. The slave hands over one byte per strobe, plus a pulse when a write transaction opens and another when it closes. The block counts the bytes of each transaction. The first byte is the device address. Two header bytes follow, and the block consumes them without looking at their values. After that come eight data bytes.

When the address matches the device's fixed write address, the first six data bytes are stored in six configuration registers. The last two data bytes, and anything sent after them, are ignored.

The registers drive the synthesizer's controls directly:
- a four-bit frequency select, with a flag that says whether frequency follows the external strap pins or the register bits;
- a two-bit operating mode (normal, spread spectrum, or all outputs three-stated);
- forty active-low clock-output disable bits.

Top module: `clkcfg_regs`

## Requirements
- R1: After synchronous reset, byte 0 is 0x00, byte 1 is 0x0F, byte 2 is 0x7F, and bytes 3 to 5 are 0xFF. This gives `freq_sel`=0, `freq_from_reg`=0, `mode`=00 and `clk_dis_n`=40'hFFFFFF7F0F.
- R2: Data bytes are stored only when the first byte after the start pulse equals 8'hD2. A transaction with any other address changes no output.
- R3: Counting the address as byte 1, bytes 4 to 9 of a transaction load data registers 0 to 5 in that order. `byte_data[7]` is the first bit on the wire.
- R4: Bytes 10 and 11 (data bytes 6 and 7) and any later bytes of the same transaction change no output.
- R5: The `mode` output decodes byte 0 bits 1:0 as follows. 00 is normal, 10 is spread spectrum and 11 is all outputs three-stated. The reserved code 01 is held in the register but appears on `mode` as 00.
- R6: `freq_from_reg` is byte 0 bit 3, where 1 means register-controlled frequency. `freq_sel[3:0]` is built from byte 0 bits {2,6,5,4}, most significant first.
- R7: `clk_dis_n[8*(k-1)+j]` equals bit j of data byte k, for k = 1 to 5. A 0 disables that clock output.
- R8: A stop pulse before the last data byte keeps every byte already written. The next start pulse restarts the byte count at the address byte.
- R9: Byte strobes that arrive after a stop pulse and before the next start pulse change no output.
- R10: A stored byte appears on the outputs at the clock edge that samples its strobe.
- R11: The values of the two header bytes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | One-cycle strobe: `byte_data` holds a complete byte |
| byte_data | input | 8 | Received byte, bit 7 first on the wire |
| xfer_start | input | 1 | One-cycle pulse opening a write transaction |
| xfer_stop | input | 1 | One-cycle pulse closing the transaction |
| freq_sel | output | 4 | Register frequency-select code |
| freq_from_reg | output | 1 | 1 = frequency from `freq_sel`, 0 = from strap pins |
| mode | output | 2 | 00 normal, 10 spread spectrum, 11 all outputs three-stated |
| clk_dis_n | output | 40 | Active-low per-output clock disables, data bytes 1 to 5 |

## Verification
The hardest case to reach from the ports is a transaction cut short. It is followed by stray strobes outside any transaction, and then a fresh transaction whose first data byte must land in register 0 again. If this fails, the counter carries over from the truncated transaction, and that only shows up in the sequence of events. The bench builds this sequence on purpose. It stops after two data bytes, sends unframed bytes, and then restarts with a distinct byte 0 value.

It also sends a full transaction with extra trailing bytes, and one with a wrong address and all-zero data. In both cases the outputs must show no change.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NUM_REGS  = 6;
  localparam int unsigned DIS_W     = (NUM_REGS - 1) * BYTE_W;

  // Reset value of configuration register i.
  function automatic logic [BYTE_W-1:0] reg_reset(input int unsigned i);
    case (i)
      0:       return 8'h00;
      1:       return 8'h0F;
      2:       return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_RSVD   = 2'b01,
    MODE_SPREAD = 2'b10,
    MODE_HIZ    = 2'b11
  } mode_e;
endpackage

// File: rtl/clkcfg_seq.sv
module clkcfg_seq #(
  parameter logic [7:0]  DEV_ADDR  = 8'hD2,
  parameter int unsigned HDR_BYTES = 3,
  parameter int unsigned NUM_DATA  = 8,
  parameter int unsigned NUM_REGS  = 6,
  localparam int unsigned TOTAL    = HDR_BYTES + NUM_DATA,
  localparam int unsigned POS_W    = $clog2(TOTAL + 1),
  localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_vld,
  input  logic [7:0]       byte_data,
  input  logic             xfer_start,
  input  logic             xfer_stop,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [POS_W-1:0] pos_q,
  output logic             addr_ok_q
);
  logic active_q;
  logic take;

  assign take = byte_vld && active_q && !xfer_start && !xfer_stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      active_q  <= 1'b0;
      addr_ok_q <= 1'b0;
    end else if (xfer_start) begin
      pos_q     <= '0;
      active_q  <= 1'b1;
      addr_ok_q <= 1'b0;
    end else if (xfer_stop) begin
      active_q  <= 1'b0;
    end else if (take) begin
      if (pos_q == '0) addr_ok_q <= (byte_data == DEV_ADDR);
      if (pos_q != POS_W'(TOTAL)) pos_q <= pos_q + 1'b1;
    end
  end

  assign wr_en  = take && addr_ok_q &&
                  (pos_q >= POS_W'(HDR_BYTES)) &&
                  (pos_q <  POS_W'(HDR_BYTES + NUM_REGS));
  assign wr_idx = IDX_W'(pos_q - POS_W'(HDR_BYTES));
endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
  import clkcfg_pkg::*;
#(
  parameter int unsigned NREGS = NUM_REGS,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [BYTE_W-1:0]            wr_data,
  output logic [NREGS-1:0][BYTE_W-1:0] regs
);
  for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[gi] <= reg_reset(gi);
      else if (wr_en && wr_idx == IDX_W'(gi))
        regs[gi] <= wr_data;
    end
  end
endmodule

// File: rtl/clkcfg_decode.sv
module clkcfg_decode
  import clkcfg_pkg::*;
(
  input  logic [NUM_REGS-1:0][BYTE_W-1:0] regs,
  output logic [3:0]                      freq_sel,
  output logic                            freq_from_reg,
  output logic [1:0]                      mode,
  output logic [DIS_W-1:0]                clk_dis_n
);
  logic [7:0] b0;
  assign b0            = regs[0];
  assign freq_sel      = {b0[2], b0[6], b0[5], b0[4]};
  assign freq_from_reg = b0[3];

  always_comb begin
    case (mode_e'(b0[1:0]))
      MODE_SPREAD: mode = MODE_SPREAD;
      MODE_HIZ:    mode = MODE_HIZ;
      default:     mode = MODE_NORMAL;
    endcase
  end

  for (genvar gk = 1; gk < NUM_REGS; gk++) begin : g_dis
    assign clk_dis_n[(gk-1)*BYTE_W +: BYTE_W] = regs[gk];
  end
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
  import clkcfg_pkg::*;
#(
  parameter logic [7:0]  DEV_ADDR  = 8'hD2,
  parameter int unsigned HDR_BYTES = 3,
  parameter int unsigned NUM_DATA  = 8,
  localparam int unsigned POS_W    = $clog2(HDR_BYTES + NUM_DATA + 1),
  localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_vld,
  input  logic [7:0]       byte_data,
  input  logic             xfer_start,
  input  logic             xfer_stop,
  output logic [3:0]       freq_sel,
  output logic             freq_from_reg,
  output logic [1:0]       mode,
  output logic [DIS_W-1:0] clk_dis_n
);
  logic                              wr_en;
  logic [IDX_W-1:0]                  wr_idx;
  logic [POS_W-1:0]                  pos_q;
  logic                              addr_ok_q;
  logic [NUM_REGS-1:0][BYTE_W-1:0]   regs;

  clkcfg_seq #(
    .DEV_ADDR (DEV_ADDR),
    .HDR_BYTES(HDR_BYTES),
    .NUM_DATA (NUM_DATA),
    .NUM_REGS (NUM_REGS)
  ) i_seq (
    .clk       (clk),
    .rst       (rst),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .xfer_start(xfer_start),
    .xfer_stop (xfer_stop),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .pos_q     (pos_q),
    .addr_ok_q (addr_ok_q)
  );

  clkcfg_regfile #(.NREGS(NUM_REGS)) i_rf (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(byte_data),
    .regs   (regs)
  );

  clkcfg_decode i_dec (
    .regs         (regs),
    .freq_sel     (freq_sel),
    .freq_from_reg(freq_from_reg),
    .mode         (mode),
    .clk_dis_n    (clk_dis_n)
  );
endmodule

// File: rtl/clkcfg_regs_chk.sv
module clkcfg_regs_chk #(
  parameter int unsigned HDR_BYTES = 3,
  parameter int unsigned NUM_DATA  = 8,
  parameter int unsigned POS_W     = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             byte_vld,
  input logic             xfer_start,
  input logic [3:0]       freq_sel,
  input logic             freq_from_reg,
  input logic [1:0]       mode,
  input logic [39:0]      clk_dis_n,
  input logic [POS_W-1:0] pos_q,
  input logic             addr_ok_q
);
  logic        rst_d;
  logic [46:0] outs;
  assign outs = {freq_sel, freq_from_reg, mode, clk_dis_n};

  always_ff @(posedge clk) rst_d <= rst;

  p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (outs == {4'h0, 1'b0, 2'b00, 40'hFFFFFF7F0F}));

  p_bad_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !xfer_start && !addr_ok_q && pos_q >= POS_W'(1)) |=> $stable(outs));

  p_tail_bytes_r4: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !xfer_start && pos_q >= POS_W'(HDR_BYTES + 6)) |=> $stable(outs));

  p_mode_rsvd_r5: assert property (@(posedge clk) disable iff (rst)
    mode != 2'b01);

  p_no_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    !byte_vld |=> $stable(outs));
endmodule

bind clkcfg_regs clkcfg_regs_chk #(
  .HDR_BYTES(HDR_BYTES),
  .NUM_DATA (NUM_DATA),
  .POS_W    (POS_W)
) i_chk (
  .clk          (clk),
  .rst          (rst),
  .byte_vld     (byte_vld),
  .xfer_start   (xfer_start),
  .freq_sel     (freq_sel),
  .freq_from_reg(freq_from_reg),
  .mode         (mode),
  .clk_dis_n    (clk_dis_n),
  .pos_q        (pos_q),
  .addr_ok_q    (addr_ok_q)
);

// File: tb/test_clkcfg_regs.sv
module test_clkcfg_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        xfer_start = 1'b0;
  logic        xfer_stop = 1'b0;
  logic [3:0]  freq_sel;
  logic        freq_from_reg;
  logic [1:0]  mode;
  logic [39:0] clk_dis_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clkcfg_regs i_clkcfg_regs (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
    .xfer_start(xfer_start), .xfer_stop(xfer_stop), .freq_sel(freq_sel),
    .freq_from_reg(freq_from_reg), .mode(mode), .clk_dis_n(clk_dis_n)
  );

  typedef struct packed {
    logic [7:0]      addr;
    logic [5:0][7:0] d;
    logic [3:0]      sel;
    logic            src;
    logic [1:0]      mode;
    logic [39:0]     dis;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t TBL [NV] = '{
    '{8'hD2, {8'hAB,8'h12,8'hF0,8'h3F,8'h0E,8'h0A}, 4'h0, 1'b1, 2'b10, 40'hAB12F03F0E},
    '{8'hD3, {8'h00,8'h00,8'h00,8'h00,8'h00,8'h00}, 4'h0, 1'b1, 2'b10, 40'hAB12F03F0E},
    '{8'hD2, {8'h3C,8'hFF,8'h00,8'h40,8'h05,8'h77}, 4'hF, 1'b0, 2'b11, 40'h3CFF004005},
    '{8'hD2, {8'hFF,8'hFF,8'hFF,8'h7F,8'h0F,8'h55}, 4'hD, 1'b0, 2'b00, 40'hFFFFFF7F0F},
    '{8'hD2, {8'h03,8'h02,8'h01,8'h00,8'h00,8'h28}, 4'h2, 1'b1, 2'b00, 40'h0302010000}
  };

  task automatic check(string req, string what, logic [39:0] act, logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req, logic [3:0] s, logic src, logic [1:0] m, logic [39:0] dis);
    check(req, "freq_sel", 40'(freq_sel), 40'(s));
    check(req, "freq_from_reg", 40'(freq_from_reg), 40'(src));
    check(req, "mode", 40'(mode), 40'(m));
    check(req, "clk_dis_n", clk_dis_n, dis);
  endtask

  task automatic pulse_start();
    xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
  endtask

  task automatic pulse_stop();
    xfer_stop = 1'b1; @(negedge clk); xfer_stop = 1'b0;
  endtask

  task automatic send(logic [7:0] b);
    byte_vld = 1'b1; byte_data = b; @(negedge clk); byte_vld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1", 4'h0, 1'b0, 2'b00, 40'hFFFFFF7F0F);

    // Table: R2 wrong address, R3 byte order, R5 mode, R6 select, R7 disables
    for (int v = 0; v < NV; v++) begin
      pulse_start();
      send(TBL[v].addr);
      send(8'h5A); send(8'hC3);
      for (int k = 0; k < 6; k++) send(TBL[v].d[k]);
      send(8'hA5); send(8'h5A);            // data bytes 6, 7 (R4)
      pulse_stop();
      check_all(v == 1 ? "R2" : "R3/R5/R6/R7", TBL[v].sel, TBL[v].src, TBL[v].mode, TBL[v].dis);
    end

    // R10: latency of one edge; R8: early stop keeps data
    pulse_start();
    send(8'hD2); send(8'h11); send(8'h22);
    check("R10", "mode before byte0", 40'(mode), 40'(2'b00));
    send(8'h03);
    check("R10", "mode after byte0 edge", 40'(mode), 40'(2'b11));
    send(8'hAA);
    pulse_stop();
    check_all("R8", 4'h0, 1'b0, 2'b11, 40'h03020100AA);

    // R9: strobes outside a transaction
    send(8'h55); send(8'h55); send(8'h55); send(8'h55);
    check_all("R9", 4'h0, 1'b0, 2'b11, 40'h03020100AA);

    // R8 restart, R11 header values equal to address / all ones, R4 extra bytes
    pulse_start();
    send(8'hD2); send(8'hD2); send(8'hFF);
    send(8'h0A);
    check("R8", "restart byte0 mode", 40'(mode), 40'(2'b10));
    check("R11", "freq_from_reg", 40'(freq_from_reg), 40'(1'b1));
    send(8'h01); send(8'h02); send(8'h03); send(8'h04); send(8'h05);
    send(8'hFF); send(8'hFF);
    check_all("R4", 4'h0, 1'b1, 2'b10, 40'h0504030201);
    send(8'hEE); send(8'hEE); send(8'hEE);
    pulse_stop();
    check_all("R4", 4'h0, 1'b1, 2'b10, 40'h0504030201);

    // R1: reset after writes
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    check_all("R1", 4'h0, 1'b0, 2'b00, 40'hFFFFFF7F0F);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule